// File: doc/BRIEF.md
# Bus Burst Sequencer

This block is the address-and-data engine of a bus master on an AHB-Lite style bus. A local client hands it one command at a time: a start address, a direction, a burst code, a transfer size and, for open-ended incrementing bursts, a beat count. The sequencer then runs the whole burst on the bus. It drives the transfer type, address and control in the address phase and the write data in the data phase. It follows slave wait states, and it computes both incrementing and wrapping address sequences.

The local side steers pacing through two inputs. `src_ready` low at a beat boundary makes the engine show BUSY until the client can go on. `src_stop`, seen during a BUSY cycle of an open-ended burst, ends that burst early. When a slave answers with an error, a configuration bit decides what happens next. Either the rest of the burst is cancelled during the two-cycle error response, or the remaining beats are still issued. The client is told about the end of every burst, and about every errored beat, through one-cycle pulses.

Top module: `ahb_burst_seq`

## Requirements
- R1: After reset the transfer type is IDLE (2'b00), `cmd_ready` is high and `done`, `err`, `rd_valid` are low.
- R2: The burst code sets the number of beats issued: 3'b000 SINGLE gives 1, 3'b001 INCR gives `cmd_beats` (0 counts as 1), 3'b010 WRAP4 and 3'b011 INCR4 give 4, 3'b100 WRAP8 and 3'b101 INCR8 give 8, 3'b110 WRAP16 and 3'b111 INCR16 give 16.
- R3: The first beat of a burst is NONSEQ (2'b10) and every later beat is SEQ (2'b11). `hburst`, `hsize` and `hwrite` carry the command values on every beat, and a cycle after IDLE is never SEQ or BUSY.
- R4: In incrementing bursts each beat address is the previous one plus 2^`hsize` bytes, with no wrap.
- R5: In wrapping bursts the wrap span is the beat count times 2^`hsize` bytes. The address bits below the span advance modulo the span, and the bits above it stay fixed.
- R6: While `hready` is low and no error is signalled, address, transfer type and control stay unchanged.
- R7: If `src_ready` is low when a beat that is not the last one is accepted, the next cycle shows BUSY (2'b01), and BUSY lasts until `src_ready` is seen high on an `hready` cycle. BUSY never follows the final beat. A fixed-length or SINGLE burst ignores `src_stop` and finishes all its beats.
- R8: In an INCR burst, `src_stop` high in a BUSY cycle that has `hready` high ends the burst: the next cycle is IDLE, and only the beats already accepted are issued.
- R9: With `cfg_err_abort` high, the first error cycle (`hresp` high, `hready` low) makes the transfer type IDLE in the second error cycle. The unissued beats are dropped, and `err` and `done` pulse together.
- R10: With `cfg_err_abort` low, an errored beat pulses `err` and the remaining beats are still issued.
- R11: `hwdata` during a write data phase equals the `wr_data` that was present when that beat's address was accepted (`beat_take` high).
- R12: A read data phase that completes with `hready` high and `hresp` low raises `rd_valid` in that cycle, with `rd_data` equal to `hrdata`.
- R13: `done` pulses for one cycle in the cycle after the burst's final data phase completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_addr | input | AW | Start address |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_burst | input | 3 | Burst code (see R2) |
| cmd_size | input | 3 | Transfer size, 2^n bytes |
| cmd_beats | input | LENW | Beat count for INCR bursts |
| cfg_err_abort | input | 1 | 1 cancels the burst on an error response |
| src_ready | input | 1 | Local side ready for the next beat |
| src_stop | input | 1 | End an INCR burst while it is in BUSY |
| wr_data | input | DW | Write data for the beat being accepted |
| beat_take | output | 1 | A beat address is accepted this cycle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DW | Read data |
| done | output | 1 | Burst finished pulse |
| err | output | 1 | Errored beat pulse |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Transfer type |
| hburst | output | 3 | Burst code on the bus |
| hsize | output | 3 | Transfer size on the bus |
| hwrite | output | 1 | Direction on the bus |
| hprot | output | 4 | Constant protection code |
| hwdata | output | DW | Write data |
| hready | input | 1 | Transfer done / not waited |
| hresp | input | 1 | Error response |
| hrdata | input | DW | Read data |

## Verification
The hardest state to reach from the ports is an error that lands while the burst is still live. The error must hit exactly the data phase of a chosen beat while the next beat's address is already presented, and the check must fall in the second error cycle. The bench's slave model counts accepted beats and raises the two-cycle error on the data phase of a selected beat index. It runs this with cancellation on a wrapping burst, with cancellation on the final beat, and without cancellation on an incrementing burst, all under a recurring wait-state pattern. BUSY handling is reached the same way, by pulling `src_ready` low in the very cycle a chosen beat is accepted, with `src_stop` raised for both open-ended and fixed bursts.

// File: rtl/ahb_burst_pkg.sv
// Shared types and helpers for the burst sequencer.
// Assumes the standard 3-bit burst and 2-bit transfer-type encodings.
package ahb_burst_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic [2:0] BU_SINGLE = 3'b000;
    localparam logic [2:0] BU_INCR   = 3'b001;
    localparam logic [2:0] BU_WRAP4  = 3'b010;
    localparam logic [2:0] BU_INCR4  = 3'b011;
    localparam logic [2:0] BU_WRAP8  = 3'b100;
    localparam logic [2:0] BU_INCR8  = 3'b101;
    localparam logic [2:0] BU_WRAP16 = 3'b110;
    localparam logic [2:0] BU_INCR16 = 3'b111;

    // Beat count of a fixed-length burst code (INCR returns 0: length from command)
    function automatic logic [4:0] fixed_beats(input logic [2:0] code);
        case (code)
            BU_SINGLE:           return 5'd1;
            BU_WRAP4, BU_INCR4:  return 5'd4;
            BU_WRAP8, BU_INCR8:  return 5'd8;
            BU_WRAP16, BU_INCR16: return 5'd16;
            default:             return 5'd0;
        endcase
    endfunction

    // True for the wrapping burst codes
    function automatic logic burst_wraps(input logic [2:0] code);
        return (code != BU_SINGLE) && (code[0] == 1'b0);
    endfunction

endpackage

// File: rtl/ahb_burst_addr.sv
// Next-beat address generator.
// Increments by the transfer size; for wrapping codes keeps the bits above
// the wrap span (beats x size) fixed and advances the bits below it modulo the span.
// Assumes the current address is aligned to the transfer size.
module ahb_burst_addr
    import ahb_burst_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [2:0]    size,
    input  logic [2:0]    burst,
    output logic [AW-1:0] nxt_addr
);

    logic [AW-1:0] step;
    logic [AW-1:0] span;
    logic [AW-1:0] low_mask;
    logic [AW-1:0] bumped;

    // Compute step, wrap span and the resulting next address
    always_comb begin
        step = AW'(1) << size;
        case (burst)
            BU_WRAP4: span = step << 2;
            BU_WRAP8: span = step << 3;
            default:  span = step << 4;
        endcase
        low_mask = span - AW'(1);
        bumped   = cur_addr + step;
        if (burst_wraps(burst))
            nxt_addr = (cur_addr & ~low_mask) | (bumped & low_mask);
        else
            nxt_addr = bumped;
    end

endmodule

// File: rtl/ahb_burst_ctrl.sv
// Address-phase controller of the burst sequencer.
// Owns the transfer type, address and control registers; advances only on
// hready, inserts BUSY between beats when the local side is not ready, ends
// INCR bursts on request from BUSY, and cancels on an error when configured.
// Assumes one command at a time and slaves that give two-cycle error responses.
module ahb_burst_ctrl
    import ahb_burst_pkg::*;
#(
    parameter int AW       = 32,
    parameter int LENW     = 8,
    parameter int MAX_SIZE = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [AW-1:0]   cmd_addr,
    input  logic            cmd_write,
    input  logic [2:0]      cmd_burst,
    input  logic [2:0]      cmd_size,
    input  logic [LENW-1:0] cmd_beats,
    input  logic            cfg_err_abort,
    input  logic            src_ready,
    input  logic            src_stop,
    input  logic            hready,
    input  logic            hresp,
    input  logic            dp_valid,
    input  logic [AW-1:0]   nxt_addr,
    output logic            cmd_ready,
    output logic [AW-1:0]   haddr,
    output logic [1:0]      htrans,
    output logic [2:0]      hburst,
    output logic [2:0]      hsize,
    output logic            hwrite,
    output logic            accept,
    output logic            acc_last,
    output logic            stop_evt,
    output logic            abort_pend
);

    trans_e          trans_q;
    logic            act_q;
    logic            abort_cfg_q;
    logic [LENW-1:0] left_q;
    logic [LENW-1:0] first_left;
    logic            is_busy;

    assign htrans    = trans_q;
    assign cmd_ready = !act_q && !dp_valid;
    assign accept    = hready && trans_q[1];
    assign acc_last  = (left_q == '0);
    assign is_busy   = (trans_q == TR_BUSY);
    assign stop_evt  = act_q && hready && is_busy && src_stop && (hburst == BU_INCR);

    // Beats remaining after the first one, from the command
    always_comb begin
        if (cmd_burst == BU_INCR)
            first_left = (cmd_beats == '0) ? '0 : cmd_beats - LENW'(1);
        else
            first_left = LENW'(fixed_beats(cmd_burst) - 5'd1);
    end

    // Address-phase state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q       <= 1'b0;
            trans_q     <= TR_IDLE;
            haddr       <= '0;
            hburst      <= BU_SINGLE;
            hsize       <= 3'd0;
            hwrite      <= 1'b0;
            left_q      <= '0;
            abort_cfg_q <= 1'b0;
            abort_pend  <= 1'b0;
        end else begin
            if (hready)
                abort_pend <= 1'b0;
            if (!act_q) begin
                if (cmd_valid && cmd_ready) begin
                    act_q       <= 1'b1;
                    trans_q     <= TR_NONSEQ;
                    haddr       <= cmd_addr;
                    hburst      <= cmd_burst;
                    hsize       <= cmd_size;
                    hwrite      <= cmd_write;
                    left_q      <= first_left;
                    abort_cfg_q <= cfg_err_abort;
                end
            end else if (hresp && !hready) begin
                if (abort_cfg_q) begin
                    act_q      <= 1'b0;
                    trans_q    <= TR_IDLE;
                    abort_pend <= 1'b1;
                end
            end else if (hready) begin
                if (trans_q[1]) begin
                    if (left_q == '0) begin
                        act_q   <= 1'b0;
                        trans_q <= TR_IDLE;
                    end else begin
                        haddr   <= nxt_addr;
                        left_q  <= left_q - LENW'(1);
                        trans_q <= src_ready ? TR_SEQ : TR_BUSY;
                    end
                end else if (src_stop && hburst == BU_INCR) begin
                    act_q   <= 1'b0;
                    trans_q <= TR_IDLE;
                end else if (src_ready) begin
                    trans_q <= TR_SEQ;
                end
            end
        end
    end

    a_r6_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (!hready && !hresp && trans_q[1]) |=> ($stable(haddr) && $stable(htrans) && $stable(hburst) && $stable(hsize)));

    a_r7_no_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        is_busy |-> (hburst != BU_SINGLE));

    a_r7_fixed_not_end_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (is_busy && hburst != BU_INCR && !hresp) |=> (htrans != 2'b00));

    a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && !hready && abort_cfg_q && htrans != 2'b00) |=> (htrans == 2'b00));

    a_r3_no_seq_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b00) |=> (htrans != 2'b11 && htrans != 2'b01));

    a_r3_size_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |-> (cmd_size <= 3'(MAX_SIZE)));

endmodule

// File: rtl/ahb_burst_dphase.sv
// Data-phase tracker of the burst sequencer.
// Registers the beat accepted in the address phase, drives write data for it,
// reports read data and raises the done / error pulses one cycle after the
// data phase (or the cancelling error) completes.
// Assumes the address-phase controller only accepts beats on hready.
module ahb_burst_dphase #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hready,
    input  logic          hresp,
    input  logic [DW-1:0] hrdata,
    input  logic          accept,
    input  logic          acc_write,
    input  logic          acc_last,
    input  logic [DW-1:0] wr_data,
    input  logic          stop_evt,
    input  logic          abort_pend,
    output logic          dp_valid,
    output logic [DW-1:0] hwdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic          err
);

    logic          dp_write;
    logic          dp_last;
    logic [DW-1:0] dp_data;
    logic          dp_end;

    assign dp_end   = dp_valid && hready;
    assign hwdata   = (dp_valid && dp_write) ? dp_data : '0;
    assign rd_valid = dp_end && !dp_write && !hresp;
    assign rd_data  = hrdata;

    // Data-phase register and completion pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_valid <= 1'b0;
            dp_write <= 1'b0;
            dp_last  <= 1'b0;
            dp_data  <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= (dp_end && dp_last) || stop_evt || (dp_end && hresp && abort_pend);
            err  <= dp_end && hresp;
            if (hready) begin
                dp_valid <= accept;
                if (accept) begin
                    dp_write <= acc_write;
                    dp_last  <= acc_last;
                    dp_data  <= wr_data;
                end
            end
        end
    end

    a_r11_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_valid && !hready && !hresp) |=> $stable(hwdata));

    a_r13_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/ahb_burst_seq.sv
// Top of the burst sequencer: joins the address-phase controller, the
// next-address generator and the data-phase tracker.
// Assumes DW/8 is a power of two and transfer sizes never exceed the data width.
module ahb_burst_seq #(
    parameter int         AW        = 32,
    parameter int         DW        = 32,
    parameter int         LENW      = 8,
    parameter logic [3:0] HPROT_VAL = 4'b0011
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [AW-1:0]   cmd_addr,
    input  logic            cmd_write,
    input  logic [2:0]      cmd_burst,
    input  logic [2:0]      cmd_size,
    input  logic [LENW-1:0] cmd_beats,
    input  logic            cfg_err_abort,
    input  logic            src_ready,
    input  logic            src_stop,
    input  logic [DW-1:0]   wr_data,
    output logic            beat_take,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data,
    output logic            done,
    output logic            err,
    output logic [AW-1:0]   haddr,
    output logic [1:0]      htrans,
    output logic [2:0]      hburst,
    output logic [2:0]      hsize,
    output logic            hwrite,
    output logic [3:0]      hprot,
    output logic [DW-1:0]   hwdata,
    input  logic            hready,
    input  logic            hresp,
    input  logic [DW-1:0]   hrdata
);

    localparam int MAX_SIZE = $clog2(DW / 8);

    logic [AW-1:0] nxt_addr;
    logic          dp_valid;
    logic          acc_last;
    logic          stop_evt;
    logic          abort_pend;

    assign hprot = HPROT_VAL;

    ahb_burst_ctrl #(
        .AW       (AW),
        .LENW     (LENW),
        .MAX_SIZE (MAX_SIZE)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_addr      (cmd_addr),
        .cmd_write     (cmd_write),
        .cmd_burst     (cmd_burst),
        .cmd_size      (cmd_size),
        .cmd_beats     (cmd_beats),
        .cfg_err_abort (cfg_err_abort),
        .src_ready     (src_ready),
        .src_stop      (src_stop),
        .hready        (hready),
        .hresp         (hresp),
        .dp_valid      (dp_valid),
        .nxt_addr      (nxt_addr),
        .cmd_ready     (cmd_ready),
        .haddr         (haddr),
        .htrans        (htrans),
        .hburst        (hburst),
        .hsize         (hsize),
        .hwrite        (hwrite),
        .accept        (beat_take),
        .acc_last      (acc_last),
        .stop_evt      (stop_evt),
        .abort_pend    (abort_pend)
    );

    ahb_burst_addr #(
        .AW (AW)
    ) u_addr (
        .cur_addr (haddr),
        .size     (hsize),
        .burst    (hburst),
        .nxt_addr (nxt_addr)
    );

    ahb_burst_dphase #(
        .DW (DW)
    ) u_dphase (
        .clk        (clk),
        .rst_n      (rst_n),
        .hready     (hready),
        .hresp      (hresp),
        .hrdata     (hrdata),
        .accept     (beat_take),
        .acc_write  (hwrite),
        .acc_last   (acc_last),
        .wr_data    (wr_data),
        .stop_evt   (stop_evt),
        .abort_pend (abort_pend),
        .dp_valid   (dp_valid),
        .hwdata     (hwdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .done       (done),
        .err        (err)
    );

endmodule

// File: tb/ahb_burst_seq_tb.sv
`timescale 1ns/1ps
module ahb_burst_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic        cmd_write = 1'b0;
    logic [2:0]  cmd_burst = '0;
    logic [2:0]  cmd_size = '0;
    logic [7:0]  cmd_beats = '0;
    logic        cfg_err_abort = 1'b0;
    logic        src_ready = 1'b1;
    logic        src_stop = 1'b0;
    logic [31:0] wr_data = '0;
    logic        beat_take, rd_valid, done, err, hwrite;
    logic [31:0] rd_data, haddr, hwdata;
    logic [1:0]  htrans;
    logic [2:0]  hburst, hsize;
    logic [3:0]  hprot;
    logic        hready = 1'b1;
    logic        hresp = 1'b0;
    logic [31:0] hrdata = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ahb_burst_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_burst(cmd_burst),
        .cmd_size(cmd_size), .cmd_beats(cmd_beats), .cfg_err_abort(cfg_err_abort),
        .src_ready(src_ready), .src_stop(src_stop), .wr_data(wr_data),
        .beat_take(beat_take), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .err(err), .haddr(haddr), .htrans(htrans), .hburst(hburst),
        .hsize(hsize), .hwrite(hwrite), .hprot(hprot), .hwdata(hwdata),
        .hready(hready), .hresp(hresp), .hrdata(hrdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] wdat(input int k);
        return 32'hC0DE_0000 + k * 32'h111;
    endfunction

    function automatic logic [31:0] rdat(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    // One burst, with the bench's own reference of beats, addresses and pulses
    task automatic run(input logic [31:0] a, input logic w, input logic [2:0] b,
                       input logic [2:0] s, input int nin, input int busy_at,
                       input bit stop, input int err_beat, input bit abort);
        int n, exp_acc, span, bytes, base;
        int k = 0, cyc = 0, dp = -1, errst = 0, busy_left = 0, err_seen = 0;
        bit done_seen = 0, exp_done = 0, busy_next = 0, stop_next = 0, prev_wait = 0, acc, stop_ev;
        logic [31:0] prev_addr;
        logic [1:0]  prev_tr;
        logic [31:0] ea[$];
        bit wraps;
        case (b)
            3'd0: n = 1;
            3'd1: n = (nin == 0) ? 1 : nin;
            3'd2, 3'd3: n = 4;
            3'd4, 3'd5: n = 8;
            default: n = 16;
        endcase
        bytes = 1 << s;
        wraps = (b == 3'd2 || b == 3'd4 || b == 3'd6);
        span  = n * bytes;
        base  = int'(a) - (int'(a) % span);
        for (int i = 0; i < n; i++)
            ea.push_back(wraps ? 32'(base + ((int'(a) - base) + i * bytes) % span)
                               : a + 32'(i * bytes));
        exp_acc = n;
        if (stop && b == 3'd1 && busy_at >= 0 && busy_at < n - 1) exp_acc = busy_at + 1;
        if (abort && err_beat >= 0 && err_beat < n) exp_acc = err_beat + 1;

        while (!cmd_ready) @(negedge clk);
        cmd_addr = a; cmd_write = w; cmd_burst = b; cmd_size = s; cmd_beats = 8'(nin);
        cfg_err_abort = abort; src_ready = 1'b1; src_stop = 1'b0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;

        while (!done_seen && cyc < 600) begin
            cyc++;
            // R13: done exactly one cycle after the final data phase
            chk(done == exp_done, "R13 done timing", 32'(done), 32'(exp_done));
            exp_done = 0;
            if (err) err_seen++;
            if (done) begin
                done_seen = 1;
                break;
            end
            if (prev_wait)
                chk(haddr == prev_addr && htrans == prev_tr, "R6 hold on wait", haddr, prev_addr);
            if (busy_next) chk(htrans == 2'b01, "R7 busy inserted", 32'(htrans), 32'h1);
            if (stop_next) chk(htrans == 2'b00, "R8 idle after stop", 32'(htrans), 32'h0);
            busy_next = 0; stop_next = 0;
            if (htrans == 2'b01) chk(b != 3'd0, "R7 no busy in single", 32'(b), 32'h0);

            // slave response for this cycle
            hresp = 1'b0;
            if (errst == 1) begin
                hready = 1'b1; hresp = 1'b1; errst = 2;
                if (abort) chk(htrans == 2'b00, "R9 idle in second error cycle", 32'(htrans), 32'h0);
            end else if (dp >= 0 && dp == err_beat && errst == 0) begin
                hready = 1'b0; hresp = 1'b1; errst = 1;
            end else begin
                hready = (cyc % 3 != 1);
            end

            // local side pacing
            stop_ev = 0;
            src_ready = 1'b1; src_stop = 1'b0;
            if (htrans == 2'b01) begin
                src_stop = stop;
                src_ready = (busy_left == 1);
                stop_ev = hready && stop && (b == 3'd1) && !hresp;
                if (hready && busy_left > 0) busy_left--;
            end
            acc = hready && htrans[1];
            if (acc && k == busy_at && k < n - 1) begin
                src_ready = 1'b0; busy_left = 2; busy_next = 1;
            end
            wr_data = wdat(k);
            hrdata  = (dp >= 0) ? rdat(ea[dp]) : 32'h0;
            #1;

            if (dp >= 0 && w) chk(hwdata == wdat(dp), "R11 write data", hwdata, wdat(dp));
            if (dp >= 0 && !w && hready && !hresp)
                chk(rd_valid && rd_data == rdat(ea[dp]), "R12 read data", rd_data, rdat(ea[dp]));
            if (acc) begin
                chk(k < exp_acc, "R2 beat count", 32'(k), 32'(exp_acc));
                chk(htrans == ((k == 0) ? 2'b10 : 2'b11), "R3 transfer type", 32'(htrans), (k == 0) ? 32'h2 : 32'h3);
                chk(hburst == b && hsize == s && hwrite == w, "R3 control", {hburst, hsize, hwrite}, {b, s, w});
                if (k < n) begin
                    if (wraps) chk(haddr == ea[k], "R5 wrap address", haddr, ea[k]);
                    else       chk(haddr == ea[k], "R4 incr address", haddr, ea[k]);
                end
            end
            if (stop_ev) stop_next = 1;
            if (hready) begin
                exp_done = ((dp >= 0) && ((dp == exp_acc - 1) || (abort && hresp))) || stop_ev;
                if (errst == 2) errst = 3;
                dp = acc ? k : -1;
                if (acc) k++;
            end
            prev_wait = !hready && !hresp && htrans[1];
            prev_addr = haddr; prev_tr = htrans;
            @(negedge clk);
        end
        hready = 1'b1; hresp = 1'b0; src_ready = 1'b1; src_stop = 1'b0;
        chk(done_seen, "R13 burst finished", 32'(done_seen), 32'h1);
        chk(k == exp_acc, "R2 beats issued", 32'(k), 32'(exp_acc));
        if (err_beat >= 0 && err_beat < n) begin
            if (abort) chk(err_seen == 1, "R9 error pulse", 32'(err_seen), 32'h1);
            else       chk(err_seen == 1, "R10 error pulse", 32'(err_seen), 32'h1);
        end else begin
            chk(err_seen == 0, "R10 no error pulse", 32'(err_seen), 32'h0);
        end
        @(negedge clk);
        chk(htrans == 2'b00, "R3 idle after burst", 32'(htrans), 32'h0);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(htrans == 2'b00, "R1 idle after reset", 32'(htrans), 32'h0);
        chk(cmd_ready == 1'b1, "R1 ready after reset", 32'(cmd_ready), 32'h1);
        chk(!done && !err && !rd_valid, "R1 pulses low", {done, err, rd_valid}, 32'h0);

        run(32'h38, 1, 3'd3, 3'd2, 0, -1, 0, -1, 0);    // R4 INCR4 write, crosses 0x40
        run(32'h38, 1, 3'd2, 3'd2, 0, -1, 0, -1, 0);    // R5 WRAP4 write, 0x3C -> 0x30
        run(32'h0E, 0, 3'd4, 3'd1, 0, -1, 0, -1, 0);    // R5 R12 WRAP8 halfword read
        run(32'hFF, 0, 3'd7, 3'd0, 0, 5, 1, -1, 0);     // R7 INCR16 byte, busy, stop ignored
        run(32'h100, 1, 3'd0, 3'd2, 0, 0, 1, -1, 0);    // R2 R7 SINGLE
        run(32'h200, 1, 3'd1, 3'd2, 6, 2, 1, -1, 0);    // R8 INCR stopped from busy
        run(32'h300, 0, 3'd1, 3'd2, 5, 1, 0, -1, 0);    // R7 INCR busy then continue
        run(32'h400, 1, 3'd1, 3'd2, 0, -1, 0, -1, 0);   // R2 INCR with zero count
        run(32'h1234, 0, 3'd6, 3'd2, 0, -1, 0, 3, 1);   // R9 WRAP16 abort on error
        run(32'h500, 1, 3'd5, 3'd2, 0, -1, 0, 2, 0);    // R10 INCR8 continue after error
        run(32'h608, 1, 3'd2, 3'd2, 0, -1, 0, 3, 1);    // R9 error on last beat

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule